// File: doc/BRIEF.md
# Streaming Packet CRC16 Checker

This block checks a fixed-length received frame as its bytes arrive, one per strobe. A frame holds 53 payload bytes and then 2 check bytes. Each accepted byte passes through a byte-wide reflected CCITT CRC16 update. The two check bytes use the same update as the payload, so a correct frame leaves a fixed residue in the register. There is no second comparison path.

The verdict appears once, after the last byte of the frame has been absorbed. A frame-start flag that arrives too early drops the frame in progress, reports a length error and starts a new frame. Between frames the checker ignores bytes until the next frame-start flag. Serial byte recovery and payload storage belong to the surrounding logic.

Top module: `pkt_crc_checker`

## Requirements
- R1: After reset, `done`, `pass` and `len_err` are low and the checker is idle. In the idle state a byte strobed without `in_sof` is ignored, so 55 such bytes produce no `done`.
- R2: A byte with `in_valid` and `in_sof` both high loads the CRC register from the preset 0xFFFF and counts as byte 1 of a new frame. `in_sof` is only looked at when `in_valid` is high.
- R3: Each accepted byte d updates the register c as follows. First t = c[7:0] ^ d. Then t = t ^ (t << 4), kept to 8 bits. Finally c = (c >> 8) ^ (t << 8) ^ (t << 3) ^ (t >> 4). This is the reflected form of polynomial 0x1021. Cycles with `in_valid` low leave the state unchanged, so gaps between bytes do not change the result.
- R4: `done` is high for exactly one cycle: the cycle that follows the clock edge at which byte 55 of a frame is accepted.
- R5: With `done`, `pass` is 1 exactly when the register after all 55 bytes equals 0xF0B8. A correct frame has this property: its two check bytes are the ones' complement of the CRC over the 53 payload bytes, sent low byte first. `pass` is 0 whenever `done` is 0.
- R6: If a byte with `in_sof` arrives after 1 to 54 bytes of a frame, then `len_err` pulses for one cycle after that edge. The old frame gives no `done`, and that byte becomes byte 1 of a new frame.
- R7: After a frame completes, bytes strobed without `in_sof` are ignored until the next frame-start flag. They cause no `done` and they do not affect the next frame's result.
- R8: A frame-start flag that arrives while the checker is idle, including on the cycle right after byte 55, raises no `len_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the strobed byte as the first byte of a frame |
| in_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle pulse after the last byte of a frame |
| pass | output | 1 | Check result, meaningful with `done` |
| len_err | output | 1 | One-cycle pulse when a frame is cut short by a new start |

## Verification
The hardest case to reach is an early restart. A frame-start flag must arrive part way through a frame, and the restarted frame must then finish cleanly. This shows that the aborted bytes left no trace in the count or in the CRC. The stimulus cuts frames after a random 1 to 54 bytes, inserts random idle gaps, and then sends a complete frame with a reference-computed check value. It also exercises the two edges where the idle state matters: a frame start on the cycle straight after byte 55, and stray bytes strobed between frames.

// File: rtl/crc16_chk_pkg.sv
package crc16_chk_pkg;

    localparam int          CRC_W       = 16;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_RUN  = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic accept;   // byte is absorbed into the CRC
        logic first;    // byte opens a new frame
        logic last;     // byte completes the frame
        logic abort;    // byte opens a frame while another is open
    } trk_ctl_t;

    // Byte-wide reflected CCITT update
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [7:0] t;
        t = c[7:0] ^ d;
        t = t ^ (t << 4);
        return (c >> 8) ^ {t, 8'h00} ^ {5'b0, t, 3'b0} ^ {12'b0, t[7:4]};
    endfunction

endpackage

// File: rtl/crc_frame_tracker.sv
module crc_frame_tracker
    import crc16_chk_pkg::*;
#(
    parameter int FRAME_LEN = 55
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_sof,
    output trk_ctl_t ctl
);
    localparam int CW = $clog2(FRAME_LEN + 1);

    trk_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_comb begin
        ctl.first  = in_valid && in_sof;
        ctl.accept = in_valid && (in_sof || state_q == TRK_RUN);
        ctl.abort  = ctl.first && state_q == TRK_RUN;
        if (ctl.first)
            ctl.last = (FRAME_LEN == 1);
        else
            ctl.last = ctl.accept && (cnt_q == CW'(FRAME_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else if (ctl.accept) begin
            if (ctl.last) begin
                state_q <= TRK_IDLE;
                cnt_q   <= '0;
            end else if (ctl.first) begin
                state_q <= TRK_RUN;
                cnt_q   <= CW'(1);
            end else begin
                cnt_q   <= cnt_q + CW'(1);
            end
        end
    end

    AST_RUN_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        state_q == TRK_RUN |-> (cnt_q >= CW'(1) && cnt_q <= CW'(FRAME_LEN - 1))); // R4
    AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        state_q == TRK_IDLE |-> cnt_q == '0); // R7
    AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ctl.abort |=> (state_q == TRK_RUN && cnt_q == CW'(1))); // R6

endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc16_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  trk_ctl_t         ctl,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = ctl.first ? CRC_PRESET : crc_q;
    assign crc_next = crc16_step(crc_base, data);

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_PRESET;
        else if (ctl.accept)
            crc_q <= crc_next;
    end

    AST_CRC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctl.accept |=> $stable(crc_q)); // R3

endmodule

// File: rtl/crc_verdict.sv
module crc_verdict
    import crc16_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  trk_ctl_t         ctl,
    input  logic [CRC_W-1:0] crc_next,
    output logic             done,
    output logic             pass,
    output logic             len_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            pass    <= 1'b0;
            len_err <= 1'b0;
        end else begin
            done    <= ctl.last;
            pass    <= ctl.last && (crc_next == CRC_RESIDUE);
            len_err <= ctl.abort;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        pass |-> done); // R5
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        len_err |-> !done); // R6

endmodule

// File: rtl/pkt_crc_checker.sv
module pkt_crc_checker
    import crc16_chk_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 53,
    parameter int CHECK_BYTES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_byte,
    output logic       done,
    output logic       pass,
    output logic       len_err
);
    localparam int FRAME_LEN = PAYLOAD_BYTES + CHECK_BYTES;

    trk_ctl_t         ctl;
    logic [CRC_W-1:0] crc_next;

    crc_frame_tracker #(.FRAME_LEN(FRAME_LEN)) u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .ctl      (ctl)
    );

    crc_byte_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .data     (in_byte),
        .crc_next (crc_next)
    );

    crc_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .crc_next (crc_next),
        .done     (done),
        .pass     (pass),
        .len_err  (len_err)
    );

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err || $past(in_valid && in_sof)); // R6

endmodule

// File: tb/tb_pkt_crc_checker.sv
`timescale 1ns/1ps
module tb_pkt_crc_checker;
    localparam int FL = 55;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       done, pass, len_err;

    int checks = 0;
    int errors = 0;
    int n_done = 0, n_err = 0, n_dbl = 0, n_stray = 0;
    logic prev_done = 1'b0, prev_err = 1'b0;
    logic [7:0] fr [FL];

    always #2.5 clk = ~clk;

    pkt_crc_checker dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .done(done), .pass(pass), .len_err(len_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (done) n_done++;
            if (len_err) n_err++;
            if ((done && prev_done) || (len_err && prev_err)) n_dbl++;
            if (pass && !done) n_stray++;
        end
        prev_done = done;
        prev_err  = len_err;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bit-serial reference, reflected polynomial 0x8408
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ fr[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return c;
    endfunction

    task automatic make_good(input int kind);
        logic [15:0] f;
        for (int i = 0; i < FL - 2; i++)
            fr[i] = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : 8'($urandom);
        f = ~ref_crc(FL - 2);
        fr[FL-2] = f[7:0];
        fr[FL-1] = f[15:8];
    endtask

    task automatic drive(input logic [7:0] b, input logic s);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_sof = s;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_byte = 8'($urandom);
    endtask

    // Sends fr[]; checks the verdict cycle when do_check is set
    task automatic send_frame(input bit gaps, input bit do_check, input string req);
        logic exp_pass;
        exp_pass = (ref_crc(FL) == 16'hF0B8);
        for (int i = 0; i < FL; i++) begin
            if (gaps && ($urandom % 4 == 0)) idle();
            drive(fr[i], i == 0);
        end
        if (do_check) begin
            idle();
            check(done === 1'b1, {req, " R4 done after byte 55"}, done, 1);
            check(pass === exp_pass, {req, " R5 pass"}, pass, exp_pass);
            idle();
            check(done === 1'b0, "R4 done one cycle", done, 0);
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0, e0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done === 0 && pass === 0 && len_err === 0, "R1 reset outputs", {done, pass, len_err}, 0);

        // R1: bytes with no frame start are ignored
        d0 = n_done;
        for (int i = 0; i < FL + 5; i++) drive(8'($urandom), 1'b0);
        idle(); idle();
        check(n_done == d0, "R1 no sof no done", n_done - d0, 0);

        // R2 R3 R5: directed frames, then random frames with gaps
        make_good(1); send_frame(0, 1, "R2 zeros");
        make_good(2); send_frame(0, 1, "R3 ones");
        for (int k = 0; k < 30; k++) begin
            make_good(0); send_frame(k % 2 == 1, 1, "R3 random");
        end

        // R5: single-bit corruption must fail
        for (int k = 0; k < 20; k++) begin
            int p;
            make_good(0);
            p = $urandom % FL;
            fr[p] = fr[p] ^ (8'h01 << ($urandom % 8));
            send_frame(1, 1, "R5 corrupt");
        end

        // R5: raw random frames against the reference residue
        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < FL; i++) fr[i] = 8'($urandom);
            send_frame(0, 1, "R5 raw");
        end

        // R6: early restart after 1..54 bytes, then a good frame
        for (int k = 0; k < 15; k++) begin
            int cut;
            cut = (k == 0) ? 1 : (k == 1) ? FL - 1 : 1 + $urandom % (FL - 1);
            d0 = n_done; e0 = n_err;
            for (int i = 0; i < cut; i++) drive(8'($urandom), i == 0);
            make_good(0);
            send_frame(1, 1, "R6 restart");
            check(n_err - e0 == 1, "R6 one len_err", n_err - e0, 1);
            check(n_done - d0 == 1, "R6 aborted frame no done", n_done - d0, 1);
        end

        // R7: stray bytes between frames are ignored
        d0 = n_done; e0 = n_err;
        make_good(0); send_frame(0, 0, "R7");
        for (int i = 0; i < 20; i++) drive(8'($urandom), 1'b0);
        make_good(0); send_frame(0, 1, "R7 after stray");
        check(n_done - d0 == 2, "R7 no extra done", n_done - d0, 2);
        check(n_err == e0, "R7 no len_err", n_err - e0, 0);

        // R8: frame start right after byte 55
        e0 = n_err; d0 = n_done;
        make_good(0); send_frame(0, 0, "R8");
        make_good(2); send_frame(0, 1, "R8 back-to-back");
        check(n_err == e0, "R8 no len_err", n_err - e0, 0);
        check(n_done - d0 == 2, "R8 both done", n_done - d0, 2);

        idle(); idle();
        check(n_dbl == 0, "R4 R6 pulses single", n_dbl, 0);
        check(n_stray == 0, "R5 pass only with done", n_stray, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule